// File: doc/BRIEF.md
# Mixed-Length Fusible Instruction Aligner

This front-end stage takes a stream of 16-bit parcels. The parcels carry a dense mix of 16-bit and 32-bit instructions. Up to two parcels arrive per cycle and enter an eight-entry parcel buffer. The buffer applies backpressure through a ready signal.

Each cycle the stage looks at the first four buffered parcels. It finds the boundary of the leading instruction from that instruction's length bit and decodes the main fields. It then emits one macro-op slot:
- If the leading instruction's fusible bit is clear, the slot holds that instruction alone.
- If the fusible bit is set, the slot holds the leading instruction as head and the next instruction as its dependent tail. The pair is issued as one unit.

A fusible head whose tail has not fully arrived waits in the buffer. No half pair ever leaves the stage. A flush input empties the buffer, including any waiting head.

Top module: `fusion_aligner`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `mop_valid` is 0 and `in_ready` is 1.
- R2: For a 16-bit instruction (first parcel bit 14 = 0), the fields decode as follows:
  - bit 15 is the fusible bit.
  - bit 13 selects the format.
  - bits 12:10 are the opcode.
  - Format 0 gives a 10-bit immediate in bits 9:0.
  - Format 1 gives the destination in bits 9:5 and the source in bits 4:0.
  - Fields a format lacks read as 0, and values are zero-extended.
- R3: For a 32-bit instruction (first parcel bit 14 = 1), the first parcel is the upper half of word w. w[31] is the fusible bit and w[29:28] selects the format. Values are zero-extended, and absent fields read 0:
  - Format 0: opcode w[27:20], immediate w[19:0].
  - Format 1: opcode w[27:20], destination w[19:15], immediate w[14:0].
  - Format 2: opcode w[27:20], destination w[19:15], source1 w[14:10], immediate w[9:0].
  - Format 3: opcode w[27:15], destination w[14:10], source1 w[9:5], source2 w[4:0].
- R4: An instruction with its fusible bit clear is emitted alone in a slot with `mop_pair` = 0. Slots leave in program order, at most one per cycle.
- R5: An instruction with its fusible bit set is emitted with the instruction that follows it in one slot with `mop_pair` = 1. This holds for every mix of 16-bit and 32-bit head and tail.
- R6: The fusible bit of a tail has no effect. The instruction after a tail starts a new slot.
- R7: While a fusible head's tail is incomplete in the buffer, no slot is emitted. When the tail completes, the whole pair is emitted.
- R8: The parcel buffer holds 8 parcels. `in_valid[0]` offers `in_p0`, and `in_valid[1]` additionally offers `in_p1`. `in_ready` is 0 when fewer than two entries are free. Parcels offered while `in_ready` is 0 are ignored.
- R9: Flush empties the buffer and any waiting head, and discards parcels offered in the same cycle. `mop_valid` is 0 in the cycle after the flush.
- R10: If the buffer is empty, an instruction whose last parcel is accepted at clock edge k appears on the slot outputs after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty buffer and drop waiting head |
| in_valid | input | 2 | Parcel offer: bit 0 for in_p0, bit 1 for in_p1 as well |
| in_p0 | input | 16 | Earlier parcel of the offered pair |
| in_p1 | input | 16 | Later parcel of the offered pair |
| in_ready | output | 1 | Buffer can take two parcels |
| mop_valid | output | 1 | Slot outputs hold a macro-op |
| mop_pair | output | 1 | Slot holds a head and a tail |
| hd_len32 | output | 1 | Head is a 32-bit instruction |
| hd_opc | output | 13 | Head opcode |
| hd_rd | output | 5 | Head destination register |
| hd_rs1 | output | 5 | Head first source register |
| hd_rs2 | output | 5 | Head second source register |
| hd_imm | output | 20 | Head immediate or displacement |
| tl_len32 | output | 1 | Tail is a 32-bit instruction |
| tl_opc | output | 13 | Tail opcode |
| tl_rd | output | 5 | Tail destination register |
| tl_rs1 | output | 5 | Tail first source register |
| tl_rs2 | output | 5 | Tail second source register |
| tl_imm | output | 20 | Tail immediate or displacement |

## Verification
The assertions assume three things about the inputs:
- `in_valid[1]` is raised only together with `in_valid[0]`.
- The parcel stream is a well-formed instruction sequence.
- The buffer count is the only thing that bounds how many parcels the aligner may consume.

The stimulus keeps within these by offering parcels only in contiguous pairs or singles, and by building every stream from complete instructions. Tails are withheld on purpose only to exercise the waiting head. Parcels offered while the buffer reports not-ready, and during a flush, are marked so that their absence can be seen in the slot stream.

// File: rtl/fa_pkg.sv
// Shared types for the fusible instruction aligner.
// Assumes 16-bit parcels; field widths cover the widest format.
package fa_pkg;
    localparam int PARCEL_W = 16;
    localparam int OPC_W    = 13;
    localparam int REG_W    = 5;
    localparam int IMM_W    = 20;

    // One decoded instruction, including its fusible bit.
    typedef struct packed {
        logic               len2;
        logic               fus;
        logic [OPC_W-1:0]   opc;
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   rs1;
        logic [REG_W-1:0]   rs2;
        logic [IMM_W-1:0]   imm;
    } insn_t;

    // Tail slot contents: the fusible bit is dropped.
    typedef struct packed {
        logic               len2;
        logic [OPC_W-1:0]   opc;
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   rs1;
        logic [REG_W-1:0]   rs2;
        logic [IMM_W-1:0]   imm;
    } slot_t;
endpackage

// File: rtl/fa_insn_dec.sv
// Combinational field extractor for one instruction.
// Assumes p_hi is the instruction's first parcel; p_lo matters only for 32-bit forms.
module fa_insn_dec
    import fa_pkg::*;
(
    input  logic [PARCEL_W-1:0] p_hi,
    input  logic [PARCEL_W-1:0] p_lo,
    output insn_t               ins
);
    logic [2*PARCEL_W-1:0] w;
    assign w = {p_hi, p_lo};

    // Pick fields by length bit and format selector.
    always_comb begin
        ins      = '0;
        ins.fus  = p_hi[15];
        ins.len2 = p_hi[14];
        if (p_hi[14]) begin
            case (w[29:28])
                2'd0: begin
                    ins.opc = {5'd0, w[27:20]};
                    ins.imm = w[19:0];
                end
                2'd1: begin
                    ins.opc = {5'd0, w[27:20]};
                    ins.rd  = w[19:15];
                    ins.imm = {5'd0, w[14:0]};
                end
                2'd2: begin
                    ins.opc = {5'd0, w[27:20]};
                    ins.rd  = w[19:15];
                    ins.rs1 = w[14:10];
                    ins.imm = {10'd0, w[9:0]};
                end
                default: begin
                    ins.opc = w[27:15];
                    ins.rd  = w[14:10];
                    ins.rs1 = w[9:5];
                    ins.rs2 = w[4:0];
                end
            endcase
        end else begin
            ins.opc = {10'd0, p_hi[12:10]};
            if (!p_hi[13]) begin
                ins.imm = {10'd0, p_hi[9:0]};
            end else begin
                ins.rd  = p_hi[9:5];
                ins.rs1 = p_hi[4:0];
            end
        end
    end
endmodule

// File: rtl/fa_parcel_buf.sv
// Circular parcel buffer: up to two pushes and up to WIN pops per cycle.
// Exposes the oldest WIN parcels as a window.
// Assumes DEPTH is a power of two and at least WIN, and that pop_n never exceeds cnt.
module fa_parcel_buf
    import fa_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIN   = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int POPW = $clog2(WIN + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [1:0]                    push_n,
    input  logic [PARCEL_W-1:0]           push_d0,
    input  logic [PARCEL_W-1:0]           push_d1,
    input  logic [POPW-1:0]               pop_n,
    output logic [WIN-1:0][PARCEL_W-1:0]  win,
    output logic [CW-1:0]                 cnt,
    output logic                          ready
);
    logic [PARCEL_W-1:0] mem [DEPTH];
    logic [PW-1:0]       rd_ptr, wr_ptr, wr_ptr1;
    logic [1:0]          acc;

    // Ready when at least two entries are free; accepted count gated by it.
    assign ready   = (cnt <= CW'(DEPTH - 2));
    assign acc     = ready ? push_n : 2'd0;
    assign wr_ptr1 = wr_ptr + 1'b1;

    // Pointer and fill-level update; flush and reset empty the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(acc);
            rd_ptr <= rd_ptr + PW'(pop_n);
            cnt    <= cnt + CW'(acc) - CW'(pop_n);
        end
    end

    // Parcel storage write (storage itself needs no reset).
    always_ff @(posedge clk) begin
        if (rst_n && !flush) begin
            if (acc != 2'd0) mem[wr_ptr]  <= push_d0;
            if (acc == 2'd2) mem[wr_ptr1] <= push_d1;
        end
    end

    // Read window: oldest WIN parcels in order.
    for (genvar i = 0; i < WIN; i++) begin : g_win
        logic [PW-1:0] idx;
        assign idx    = rd_ptr + PW'(i);
        assign win[i] = mem[idx];
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R8
    blocked_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> cnt <= $past(cnt));
endmodule

// File: rtl/fa_mop_former.sv
// Finds the leading instruction in the parcel window.
// If it is fusible, attaches the following instruction, then registers one macro-op slot per cycle.
// Assumes a window of four parcels, enough for a 32-bit head plus a 32-bit tail.
module fa_mop_former
    import fa_pkg::*;
#(
    parameter int WIN   = 4,
    parameter int CNT_W = 4,
    localparam int POPW = $clog2(WIN + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [WIN-1:0][PARCEL_W-1:0]  win,
    input  logic [CNT_W-1:0]              cnt,
    output logic [POPW-1:0]               pop_n,
    output logic                          mop_valid,
    output insn_t                         hd_q,
    output slot_t                         tl_q
);
    insn_t               h, t;
    logic [PARCEL_W-1:0] t_hi, t_lo;
    logic [POPW-1:0]     h_n, t_n, need;
    logic                can_emit;

    fa_insn_dec u_hd (.p_hi(win[0]), .p_lo(win[1]), .ins(h));

    // Tail starts right after the head.
    assign t_hi = h.len2 ? win[2] : win[1];
    assign t_lo = h.len2 ? win[3] : win[2];

    fa_insn_dec u_tl (.p_hi(t_hi), .p_lo(t_lo), .ins(t));

    // Parcel counts and the emit decision; a garbage tail length is harmless since it is always >= 1.
    always_comb begin
        h_n      = h.len2 ? POPW'(2) : POPW'(1);
        t_n      = t.len2 ? POPW'(2) : POPW'(1);
        need     = h.fus ? POPW'(h_n + t_n) : h_n;
        can_emit = (cnt >= CNT_W'(h_n)) && (!h.fus || (cnt >= CNT_W'(need)));
        pop_n    = (can_emit && !flush) ? need : '0;
    end

    // Slot output register; cleared on reset, flush and idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            mop_valid <= 1'b0;
            hd_q      <= '0;
            tl_q      <= '0;
        end else begin
            mop_valid <= can_emit;
            hd_q      <= can_emit ? h : '0;
            tl_q      <= (can_emit && h.fus) ?
                         {t.len2, t.opc, t.rd, t.rs1, t.rs2, t.imm} : '0;
        end
    end

    // R6
    tail_no_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (can_emit && !flush && h.fus && t.fus) |=> (mop_valid && hd_q.fus));
endmodule

// File: rtl/fusion_aligner.sv
// Top of the mixed-length fusible instruction aligner.
// Connects the parcel buffer to the macro-op former and flattens the slot.
// Assumes in_valid[1] is asserted only with in_valid[0].
module fusion_aligner
    import fa_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIN   = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int POPW = $clog2(WIN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [1:0]          in_valid,
    input  logic [PARCEL_W-1:0] in_p0,
    input  logic [PARCEL_W-1:0] in_p1,
    output logic                in_ready,
    output logic                mop_valid,
    output logic                mop_pair,
    output logic                hd_len32,
    output logic [OPC_W-1:0]    hd_opc,
    output logic [REG_W-1:0]    hd_rd,
    output logic [REG_W-1:0]    hd_rs1,
    output logic [REG_W-1:0]    hd_rs2,
    output logic [IMM_W-1:0]    hd_imm,
    output logic                tl_len32,
    output logic [OPC_W-1:0]    tl_opc,
    output logic [REG_W-1:0]    tl_rd,
    output logic [REG_W-1:0]    tl_rs1,
    output logic [REG_W-1:0]    tl_rs2,
    output logic [IMM_W-1:0]    tl_imm
);
    logic [1:0]                   push_n;
    logic [POPW-1:0]              pop_n;
    logic [WIN-1:0][PARCEL_W-1:0] win;
    logic [CW-1:0]                buf_cnt;
    insn_t                        hd_q;
    slot_t                        tl_q;

    // Offered parcel count: bit 1 counts only alongside bit 0.
    assign push_n = in_valid[0] ? (in_valid[1] ? 2'd2 : 2'd1) : 2'd0;

    fa_parcel_buf #(.DEPTH(DEPTH), .WIN(WIN)) u_buf (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_n(push_n), .push_d0(in_p0), .push_d1(in_p1),
        .pop_n(pop_n), .win(win), .cnt(buf_cnt), .ready(in_ready)
    );

    fa_mop_former #(.WIN(WIN), .CNT_W(CW)) u_form (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .win(win), .cnt(buf_cnt), .pop_n(pop_n),
        .mop_valid(mop_valid), .hd_q(hd_q), .tl_q(tl_q)
    );

    // Flatten slot fields onto ports; a registered fusible head marks a pair.
    assign mop_pair = hd_q.fus;
    assign hd_len32 = hd_q.len2;
    assign hd_opc   = hd_q.opc;
    assign hd_rd    = hd_q.rd;
    assign hd_rs1   = hd_q.rs1;
    assign hd_rs2   = hd_q.rs2;
    assign hd_imm   = hd_q.imm;
    assign tl_len32 = tl_q.len2;
    assign tl_opc   = tl_q.opc;
    assign tl_rd    = tl_q.rd;
    assign tl_rs1   = tl_q.rs1;
    assign tl_rs2   = tl_q.rs2;
    assign tl_imm   = tl_q.imm;

    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !mop_valid);

    // R5
    pair_has_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mop_pair |-> mop_valid);

    // R7
    pop_within_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_n) <= buf_cnt);
endmodule

// File: tb/tb_fusion_aligner.sv
`timescale 1ns/1ps
module tb_fusion_aligner;
    typedef logic [48:0] ins_t;                 // {len32, opc13, rd, rs1, rs2, imm20}
    typedef logic [98:0] obs_t;                 // {pair, head, tail}

    logic        clk = 0, rst_n = 0, flush = 0;
    logic [1:0]  in_valid = 0;
    logic [15:0] in_p0 = 0, in_p1 = 0;
    logic        in_ready, mop_valid, mop_pair, hd_len32, tl_len32;
    logic [12:0] hd_opc, tl_opc;
    logic [4:0]  hd_rd, hd_rs1, hd_rs2, tl_rd, tl_rs1, tl_rs2;
    logic [19:0] hd_imm, tl_imm;
    int checks = 0, fails = 0;
    obs_t got[$];
    obs_t expq[$];

    always #5 clk = ~clk;

    fusion_aligner dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_p0(in_p0), .in_p1(in_p1), .in_ready(in_ready),
        .mop_valid(mop_valid), .mop_pair(mop_pair),
        .hd_len32(hd_len32), .hd_opc(hd_opc), .hd_rd(hd_rd), .hd_rs1(hd_rs1),
        .hd_rs2(hd_rs2), .hd_imm(hd_imm),
        .tl_len32(tl_len32), .tl_opc(tl_opc), .tl_rd(tl_rd), .tl_rs1(tl_rs1),
        .tl_rs2(tl_rs2), .tl_imm(tl_imm)
    );

    function automatic ins_t mk(input logic l, input logic [12:0] o, input logic [4:0] d,
                                input logic [4:0] s1, input logic [4:0] s2, input logic [19:0] im);
        return {l, o, d, s1, s2, im};
    endfunction
    function automatic obs_t one(input ins_t h);
        return {1'b0, h, 49'd0};
    endfunction
    function automatic obs_t two(input ins_t h, input ins_t t);
        return {1'b1, h, t};
    endfunction
    function automatic obs_t cur();
        return {mop_pair, hd_len32, hd_opc, hd_rd, hd_rs1, hd_rs2, hd_imm,
                tl_len32, tl_opc, tl_rd, tl_rs1, tl_rs2, tl_imm};
    endfunction

    // Collect every emitted slot.
    always @(negedge clk) if (rst_n && mop_valid) got.push_back(cur());

    task automatic chk(input bit ok, input string req, input obs_t act, input obs_t exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] a, input logic [15:0] b, input int n);
        while (!in_ready) @(negedge clk);
        in_p0 = a; in_p1 = b;
        in_valid = (n == 2) ? 2'b11 : 2'b01;
        @(negedge clk);
        in_valid = 2'b00;
    endtask

    task automatic drain_and_compare(input string req);
        repeat (12) @(negedge clk);
        chk(got.size() == expq.size(), req, obs_t'(got.size()), obs_t'(expq.size()));
        for (int i = 0; i < expq.size() && i < got.size(); i++)
            chk(got[i] == expq[i], req, got[i], expq[i]);
        got.delete(); expq.delete();
    endtask

    localparam ins_t I1733 = {1'b0, 13'd5, 5'd0, 5'd0, 5'd0, 20'h00333};
    localparam ins_t I2CE9 = {1'b0, 13'd3, 5'd7, 5'd9, 5'd0, 20'h0};
    localparam ins_t IF0   = {1'b1, 13'hA5, 5'd0, 5'd0, 5'd0, 20'h12345};
    localparam ins_t IF1   = {1'b1, 13'h3C, 5'd17, 5'd0, 5'd0, 20'h01234};
    localparam ins_t IF2   = {1'b1, 13'h7E, 5'd5, 5'd6, 5'd0, 20'h002AB};
    localparam ins_t IF3   = {1'b1, 13'h1ABC, 5'd1, 5'd2, 5'd3, 20'h0};

    // R1: reset state
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!mop_valid && in_ready, "R1 during reset", obs_t'({mop_valid, in_ready}), obs_t'(2'b01));
        rst_n = 1;
        chk(!mop_valid && in_ready, "R1 after release", obs_t'({mop_valid, in_ready}), obs_t'(2'b01));
        @(negedge clk);
    endtask

    // R2, R4, R10: two 16-bit singles, exact cycle of appearance
    task automatic t_short_latency();
        send(16'h1733, 16'h2CE9, 2);
        chk(!mop_valid, "R10 not before edge k+1", obs_t'(mop_valid), 0);
        @(negedge clk);
        chk(mop_valid && cur() == one(I1733), "R10 R2 first 16-bit fmt0", cur(), one(I1733));
        @(negedge clk);
        chk(mop_valid && cur() == one(I2CE9), "R2 R4 second 16-bit fmt1", cur(), one(I2CE9));
        @(negedge clk);
        chk(!mop_valid, "R4 no extra slot", obs_t'(mop_valid), 0);
        got.delete();
    endtask

    // R3: all four 32-bit formats
    task automatic t_long_formats();
        send(16'h4A51, 16'h2345, 2);
        send(16'h53C8, 16'h9234, 2);
        send(16'h67E2, 16'h9AAB, 2);
        send(16'h7D5E, 16'h0443, 2);
        expq.push_back(one(IF0)); expq.push_back(one(IF1));
        expq.push_back(one(IF2)); expq.push_back(one(IF3));
        drain_and_compare("R3 32-bit formats");
    endtask

    // R5: mixed-length pairs
    task automatic t_pairs();
        send(16'hACE9, 16'h67E2, 2);
        send(16'h9AAB, 16'hCA51, 2);
        send(16'h2345, 16'h1733, 2);
        expq.push_back(two(I2CE9, IF2));
        expq.push_back(two(IF0, I1733));
        drain_and_compare("R5 fused pairs");
    endtask

    // R6: fusible tail does not chain
    task automatic t_no_chain();
        send(16'h9733, 16'hACE9, 2);
        send(16'h1733, 16'h0000, 1);
        expq.push_back(two(I1733, I2CE9));
        expq.push_back(one(I1733));
        drain_and_compare("R6 tail fusible bit ignored");
    endtask

    // R7: head waits for an incomplete tail
    task automatic t_hold();
        send(16'hCA51, 16'h2345, 2);
        send(16'h4A51, 16'h0000, 1);
        repeat (5) @(negedge clk);
        chk(got.size() == 0 && !mop_valid, "R7 held head emits nothing",
            obs_t'(got.size()), 0);
        send(16'h2345, 16'h0000, 1);
        expq.push_back(two(IF0, IF0));
        drain_and_compare("R7 pair after tail completes");
    endtask

    // R9: flush drops waiting head and same-cycle parcels
    task automatic t_flush();
        send(16'hACE9, 16'h0000, 1);
        repeat (3) @(negedge clk);
        flush = 1; in_p0 = 16'h1733; in_valid = 2'b01;
        @(negedge clk);
        flush = 0; in_valid = 2'b00;
        chk(!mop_valid, "R9 quiet after flush", obs_t'(mop_valid), 0);
        send(16'h2CE9, 16'h0000, 1);
        expq.push_back(one(I2CE9));
        drain_and_compare("R9 flush discards head");
    endtask

    // R8: backpressure; junk offered while not ready must vanish
    task automatic t_backpressure();
        int idx = 0;
        bit saw_low = 0;
        while (idx < 16) begin
            if (in_ready) begin
                in_p0 = 16'h0400 | 16'(idx); in_p1 = 16'h0400 | 16'(idx + 1);
                idx += 2;
            end else begin
                in_p0 = 16'h07FF; in_p1 = 16'h07FF;
                saw_low = 1;
            end
            in_valid = 2'b11;
            @(negedge clk);
        end
        in_valid = 2'b00;
        chk(saw_low, "R8 ready deasserts when nearly full", obs_t'(saw_low), 1);
        for (int i = 0; i < 16; i++) expq.push_back(one(mk(1'b0, 13'd1, 5'd0, 5'd0, 5'd0, 20'(i))));
        repeat (10) @(negedge clk);
        drain_and_compare("R8 accepted parcels only, in order");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_short_latency();
        t_long_formats();
        t_pairs();
        t_no_chain();
        t_hold();
        t_flush();
        t_backpressure();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule